// File: doc/BRIEF.md
# Packed SPI Word Access Adapter

This block sits between a 32-bit register bus and the transmit and receive word FIFOs of one SPI channel. A bus access targets the channel's data path: a write hands words to the transmit FIFO, and a read collects words from the receive FIFO. When the packed-access control bit is set and the configuration allows it, one 32-bit access moves several short SPI words. A word length of 3 to 7 bits packs four words into byte lanes. A word length of 8 to 15 bits packs two words into halfword lanes. A longer word moves alone. The earliest word in FIFO order always occupies the lowest lane.

The block checks the configuration on every access. Packing needs the FIFO enabled and both FIFO level thresholds ending in binary 11. If a word count is in use, it must be divisible by the packing factor. When packed mode is requested and any of these conditions fails, a configuration-error flag rises and accesses fall back to one word each. Before it moves any data, the block also refuses an access that would overflow or underflow the FIFO, and a packed-mode access narrower than 32 bits.

Both FIFO sides use valid/ready. On the transmit side, `tx_valid` stays high and `tx_data` stays stable until `tx_ready` accepts the word. On the receive side, `rx_ready` stays high until `rx_valid` delivers the next word. One word moves per handshake cycle. The requester holds `bus_req` and its fields steady until it sees the one-cycle `bus_ack`.

Top module: `spi_pack_adapter`

## Requirements
- R1: After reset, `bus_ack`, `bus_err`, `tx_valid` and `rx_ready` are low and `bus_rdata` is zero.
- R2: With packing active and a word length of 3 to 7, a write pushes four words. Word k is byte k of `bus_wdata` (bits 8k+7..8k), masked to the word length, and word 0 is pushed first.
- R3: With packing active and a word length of 8 to 15, a write pushes two words, taken from the low and then the high halfword and masked to the word length.
- R4: With packing off, the FIFO disabled, or a word length of 16 or more, an access moves exactly one word, taken from the low bits and masked to the word length. A length of 32 passes all bits.
- R5: A read places each popped word, masked to the word length, right-justified in its lane, with the first popped word in the lowest lane. All other bits of `bus_rdata` read as zero, and `bus_rdata` is zero whenever `bus_ack` is low.
- R6: `cfg_err` is high exactly when packed mode is requested and one of the following holds. In each case the access falls back to one word:
  - the FIFO is disabled;
  - the low two bits of either level threshold are not 11;
  - a nonzero word count has nonzero low two bits in four-word mode;
  - a nonzero word count has a nonzero low bit in two-word mode.
- R7: With packed mode requested, an access whose size code is not 2 (word; 0 is byte, 1 is halfword) is refused with `bus_err` and moves no words.
- R8: A write is refused with `bus_err`, and pushes nothing, when `tx_free` is less than the number of words the access would move.
- R9: A read is refused with `bus_err`, with zero data and no pop, when `rx_count` is less than the number of words the access would move.
- R10: While `tx_valid` waits for `tx_ready`, `tx_data` holds. The block never offers a transmit word and accepts a receive word in the same cycle. Exactly one word moves per handshake.
- R11: `bus_ack` is a one-cycle pulse. It comes one cycle after the request for a refused access, and one cycle after the last word handshake for an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pack_en | input | 1 | Packed access requested |
| cfg_fifo_en | input | 1 | Channel FIFO enabled |
| cfg_wlen | input | 6 | SPI word length in bits (3 to 32) |
| cfg_ae_lvl | input | 8 | Almost-empty level threshold |
| cfg_af_lvl | input | 8 | Almost-full level threshold |
| cfg_wcnt | input | 16 | Transfer word count, 0 when unused |
| cfg_err | output | 1 | Packed mode requested under an illegal configuration |
| bus_req | input | 1 | Data register access request, held until acknowledged |
| bus_we | input | 1 | 1 write (transmit), 0 read (receive) |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Access refused, valid with bus_ack |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| tx_free | input | 6 | Free entries in the transmit FIFO |
| tx_valid | output | 1 | Transmit word offered |
| tx_ready | input | 1 | Transmit FIFO accepts the word |
| tx_data | output | 32 | Transmit word, right-justified |
| rx_count | input | 6 | Words held in the receive FIFO |
| rx_valid | input | 1 | Receive word available |
| rx_ready | output | 1 | Adapter takes the receive word |
| rx_data | input | 32 | Receive word, right-justified |

## Verification
A wrong word index or a latched mode that does not match the configuration shows at the ports within a single access. On the transmit side, the words appear in the wrong order or with the wrong mask. On the receive side, bytes or halfwords land in the wrong lane of the returned data. A miscounted word total shows as extra or missing FIFO handshakes, and the acknowledge arrives early or late, one cycle per word of error. A faulty legality or room check appears on the first access under the bad configuration: the error bit is wrong, or the handshake count is wrong, or the configuration-error output fails to match the settings.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

  typedef enum logic [1:0] {PK_ONE = 2'd0, PK_TWO = 2'd1, PK_FOUR = 2'd2} pack_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_MOVE = 2'd1, S_ACK = 2'd2} seq_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [2:0] words_of(pack_e m);
    case (m)
      PK_FOUR: return 3'd4;
      PK_TWO:  return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [5:0] lane_of(pack_e m);
    case (m)
      PK_FOUR: return 6'd8;
      PK_TWO:  return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/spi_pack_cfg.sv
module spi_pack_cfg
  import spi_pack_pkg::*;
#(
  parameter int WLW  = 6,
  parameter int LVLW = 8,
  parameter int WCW  = 16
) (
  input  logic            pack_en,
  input  logic            fifo_en,
  input  logic [WLW-1:0]  wlen,
  input  logic [LVLW-1:0] ae_lvl,
  input  logic [LVLW-1:0] af_lvl,
  input  logic [WCW-1:0]  wcnt,
  output logic            cfg_err,
  output pack_e           mode
);
  pack_e raw;
  logic  lvl_ok, wc_ok;

  always_comb begin
    if (wlen <= WLW'(7))       raw = PK_FOUR;
    else if (wlen <= WLW'(15)) raw = PK_TWO;
    else                       raw = PK_ONE;

    lvl_ok = (ae_lvl[1:0] == 2'b11) && (af_lvl[1:0] == 2'b11);

    if (wcnt == '0)          wc_ok = 1'b1;
    else if (raw == PK_FOUR) wc_ok = (wcnt[1:0] == 2'b00);
    else if (raw == PK_TWO)  wc_ok = ~wcnt[0];
    else                     wc_ok = 1'b1;

    cfg_err = pack_en && !(fifo_en && lvl_ok && wc_ok);
    mode    = (pack_en && !cfg_err) ? raw : PK_ONE;
  end
endmodule

// File: rtl/spi_pack_lanes.sv
module spi_pack_lanes
  import spi_pack_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WLW = 6
) (
  input  pack_e           mode,
  input  logic [WLW-1:0]  wlen,
  input  logic [1:0]      idx,
  input  logic [DW-1:0]   src,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   rx_word,
  output logic [DW-1:0]   tx_word,
  output logic [DW-1:0]   acc_next
);
  logic [DW-1:0] wmask;
  logic [5:0]    shift;

  always_comb begin
    wmask    = (wlen >= WLW'(DW)) ? '1 : ((DW'(1) << wlen) - DW'(1));
    shift    = 6'(idx) * lane_of(mode);
    tx_word  = (src >> shift) & wmask;
    acc_next = acc | ((rx_word & wmask) << shift);
  end
endmodule

// File: rtl/spi_pack_seq.sv
module spi_pack_seq
  import spi_pack_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WLW  = 6,
  parameter int CNTW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pack_en,
  input  pack_e           mode,
  input  logic [WLW-1:0]  wlen,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [1:0]      bus_size,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [CNTW-1:0] tx_free,
  input  logic            tx_ready,
  input  logic [CNTW-1:0] rx_count,
  input  logic            rx_valid,
  input  logic [DW-1:0]   acc_next,
  output pack_e           mode_q,
  output logic [WLW-1:0]  wlen_q,
  output logic [1:0]      idx,
  output logic [DW-1:0]   data_q,
  output logic            bus_ack,
  output logic            bus_err,
  output logic [DW-1:0]   bus_rdata,
  output logic            tx_valid,
  output logic            rx_ready
);
  seq_e state;
  logic is_rd, err_q;
  logic size_bad, short, last, hs;
  logic [2:0] nwords;

  always_comb begin
    nwords   = words_of(mode);
    size_bad = pack_en && (bus_size != SZ_WORD);
    short    = bus_we ? (tx_free < CNTW'(nwords)) : (rx_count < CNTW'(nwords));
    last     = (idx == 2'(words_of(mode_q) - 3'd1));
    hs       = (state == S_MOVE) && (is_rd ? rx_valid : tx_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= PK_ONE;
      wlen_q <= '0;
      idx    <= '0;
      data_q <= '0;
      is_rd  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (bus_req) begin
          mode_q <= mode;
          wlen_q <= wlen;
          is_rd  <= !bus_we;
          idx    <= '0;
          if (size_bad || short) begin
            err_q  <= 1'b1;
            data_q <= '0;
            state  <= S_ACK;
          end else begin
            err_q  <= 1'b0;
            data_q <= bus_we ? bus_wdata : '0;
            state  <= S_MOVE;
          end
        end
        S_MOVE: if (hs) begin
          if (is_rd) data_q <= acc_next;
          idx <= idx + 2'd1;
          if (last) state <= S_ACK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_ack   = (state == S_ACK);
  assign bus_err   = bus_ack && err_q;
  assign bus_rdata = (bus_ack && is_rd) ? data_q : '0;
  assign tx_valid  = (state == S_MOVE) && !is_rd;
  assign rx_ready  = (state == S_MOVE) && is_rd;
endmodule

// File: rtl/spi_pack_adapter.sv
module spi_pack_adapter
  import spi_pack_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WLW  = 6,
  parameter int LVLW = 8,
  parameter int WCW  = 16,
  parameter int CNTW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_pack_en,
  input  logic            cfg_fifo_en,
  input  logic [WLW-1:0]  cfg_wlen,
  input  logic [LVLW-1:0] cfg_ae_lvl,
  input  logic [LVLW-1:0] cfg_af_lvl,
  input  logic [WCW-1:0]  cfg_wcnt,
  output logic            cfg_err,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic [1:0]      bus_size,
  input  logic [DW-1:0]   bus_wdata,
  output logic            bus_ack,
  output logic            bus_err,
  output logic [DW-1:0]   bus_rdata,
  input  logic [CNTW-1:0] tx_free,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic [CNTW-1:0] rx_count,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data
);
  pack_e          mode, mode_q;
  logic [WLW-1:0] wlen_q;
  logic [1:0]     idx;
  logic [DW-1:0]  data_q, acc_next;

  spi_pack_cfg #(.WLW(WLW), .LVLW(LVLW), .WCW(WCW)) u_cfg (
    .pack_en(cfg_pack_en), .fifo_en(cfg_fifo_en), .wlen(cfg_wlen),
    .ae_lvl(cfg_ae_lvl), .af_lvl(cfg_af_lvl), .wcnt(cfg_wcnt),
    .cfg_err(cfg_err), .mode(mode)
  );

  spi_pack_seq #(.DW(DW), .WLW(WLW), .CNTW(CNTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pack_en(cfg_pack_en), .mode(mode), .wlen(cfg_wlen),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .tx_free(tx_free), .tx_ready(tx_ready), .rx_count(rx_count), .rx_valid(rx_valid),
    .acc_next(acc_next), .mode_q(mode_q), .wlen_q(wlen_q), .idx(idx), .data_q(data_q),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .rx_ready(rx_ready)
  );

  spi_pack_lanes #(.DW(DW), .WLW(WLW)) u_lanes (
    .mode(mode_q), .wlen(wlen_q), .idx(idx), .src(data_q), .acc(data_q),
    .rx_word(rx_data), .tx_word(tx_data), .acc_next(acc_next)
  );
endmodule

// File: rtl/spi_pack_chk.sv
module spi_pack_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          bus_err,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          rx_ready
);
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R11
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(bus_req));

  // R5
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));

  // R8
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_err) |-> (!$past(tx_valid) && !$past(rx_ready)));
endmodule

bind spi_pack_adapter spi_pack_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack), .bus_err(bus_err),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready)
);

// File: tb/spi_pack_adapter_test.sv
`timescale 1ns/100ps
module spi_pack_adapter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_pack_en = 1'b0, cfg_fifo_en = 1'b1;
  logic [5:0]  cfg_wlen = 6'd8;
  logic [7:0]  cfg_ae_lvl = 8'h03, cfg_af_lvl = 8'h07;
  logic [15:0] cfg_wcnt = '0;
  logic        cfg_err;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ack, bus_err;
  logic [5:0]  tx_free = 6'd8, rx_count = 6'd8;
  logic        tx_valid, tx_ready = 1'b1, rx_valid = 1'b1, rx_ready;
  logic [31:0] tx_data, rx_data;

  int checks = 0, fails = 0;
  int rx_ptr = 0, ncap = 0;
  logic bp = 1'b0;
  logic [31:0] cap [8];

  always #2.5 clk = ~clk;

  spi_pack_adapter uut (.*);

  function automatic logic [31:0] src_word(int k);
    return 32'h5A3C_96E1 + 32'(k) * 32'h1357_9BDF;
  endfunction
  assign rx_data = src_word(rx_ptr);

  function automatic logic [31:0] wmask(logic [5:0] wl);
    return (wl >= 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 32'h1);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: back-pressure pattern, transmit capture, receive pointer advance
  initial forever begin
    @(negedge clk);
    tx_ready = bp ? ~tx_ready : 1'b1;
    if (tx_valid && tx_ready && ncap < 8) begin cap[ncap] = tx_data; ncap++; end
    if (rx_valid && rx_ready) begin @(posedge clk); #1 rx_ptr++; end
  end

  typedef struct packed {
    logic pk; logic fe; logic [5:0] wl; logic [1:0] ae; logic [1:0] af; logic [7:0] wc;
    logic rd; logic [1:0] sz; logic [31:0] wd; logic [3:0] lvl;
    logic [2:0] xn; logic xerr; logic xcfg;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd2,32'hDEAD_BEEF,4'd8,3'd4,1'b0,1'b0}, // R2
    '{1'b1,1'b1,6'd12,2'b11,2'b11,8'h00,1'b0,2'd2,32'hCAFE_F00D,4'd8,3'd2,1'b0,1'b0}, // R3
    '{1'b1,1'b1,6'd16,2'b11,2'b11,8'h00,1'b0,2'd2,32'h1234_ABCD,4'd8,3'd1,1'b0,1'b0}, // R4
    '{1'b1,1'b1,6'd32,2'b11,2'b11,8'h00,1'b0,2'd2,32'h8765_4321,4'd8,3'd1,1'b0,1'b0}, // R4
    '{1'b0,1'b1,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd2,32'hFFFF_FFF3,4'd8,3'd1,1'b0,1'b0}, // R4
    '{1'b1,1'b0,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd2,32'h0000_00F7,4'd8,3'd1,1'b0,1'b1}, // R6
    '{1'b1,1'b1,6'd5, 2'b01,2'b11,8'h00,1'b0,2'd2,32'h0000_0055,4'd8,3'd1,1'b0,1'b1}, // R6
    '{1'b1,1'b1,6'd5, 2'b11,2'b11,8'h06,1'b0,2'd2,32'h0000_0AA9,4'd8,3'd1,1'b0,1'b1}, // R6
    '{1'b1,1'b1,6'd12,2'b11,2'b11,8'h06,1'b0,2'd2,32'h0F0F_F0F0,4'd8,3'd2,1'b0,1'b0}, // R6
    '{1'b1,1'b1,6'd12,2'b11,2'b10,8'h00,1'b0,2'd2,32'h0000_1FFF,4'd8,3'd1,1'b0,1'b1}, // R6
    '{1'b1,1'b1,6'd5, 2'b11,2'b11,8'h00,1'b1,2'd2,32'h0,        4'd8,3'd4,1'b0,1'b0}, // R5
    '{1'b1,1'b1,6'd12,2'b11,2'b11,8'h00,1'b1,2'd2,32'h0,        4'd8,3'd2,1'b0,1'b0}, // R5
    '{1'b0,1'b1,6'd20,2'b11,2'b11,8'h00,1'b1,2'd2,32'h0,        4'd8,3'd1,1'b0,1'b0}, // R5
    '{1'b1,1'b1,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd1,32'h0102_0304,4'd8,3'd0,1'b1,1'b0}, // R7
    '{1'b1,1'b0,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd0,32'h0000_0011,4'd8,3'd0,1'b1,1'b1}, // R7
    '{1'b1,1'b1,6'd5, 2'b11,2'b11,8'h00,1'b0,2'd2,32'h1111_1111,4'd3,3'd0,1'b1,1'b0}, // R8
    '{1'b1,1'b1,6'd12,2'b11,2'b11,8'h00,1'b1,2'd2,32'h0,        4'd1,3'd0,1'b1,1'b0}, // R9
    '{1'b0,1'b1,6'd8, 2'b11,2'b11,8'h00,1'b0,2'd0,32'h0000_01A5,4'd8,3'd1,1'b0,1'b0}  // R4
  };

  task automatic run_vec(input vec_t v, input int min_lat);
    int base, cyc, lane, moved, exp_lat;
    string tag;
    logic [31:0] m, exp_rd;
    @(negedge clk);
    cfg_pack_en = v.pk; cfg_fifo_en = v.fe; cfg_wlen = v.wl;
    cfg_ae_lvl = {6'h05, v.ae}; cfg_af_lvl = {6'h09, v.af}; cfg_wcnt = {8'h00, v.wc};
    tx_free = {2'b00, v.lvl}; rx_count = {2'b00, v.lvl};
    bus_we = !v.rd; bus_size = v.sz; bus_wdata = v.wd;
    #1;
    chk(cfg_err == v.xcfg, "R6 cfg_err", 32'(cfg_err), 32'(v.xcfg));
    base = rx_ptr; ncap = 0;
    bus_req = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!bus_ack && cyc < 40);
    lane = (v.xn == 3'd4) ? 8 : (v.xn == 3'd2) ? 16 : 32;
    m = wmask(v.wl);
    tag = v.xerr ? "R7/R8/R9" : (v.rd ? "R5" : (v.xn == 3'd4) ? "R2" : (v.xn == 3'd2) ? "R3" : "R4");
    chk(bus_ack, "R11 ack seen", 32'(bus_ack), 32'd1);
    chk(bus_err == v.xerr, {tag, " bus_err"}, 32'(bus_err), 32'(v.xerr));
    exp_lat = v.xerr ? 1 : int'(v.xn) + 1;
    if (min_lat == 0) chk(cyc == exp_lat, "R11 ack latency", 32'(cyc), 32'(exp_lat));
    else chk(cyc >= min_lat, "R10 latency under back-pressure", 32'(cyc), 32'(min_lat));
    moved = v.rd ? (rx_ptr - base) : ncap;
    chk(moved == (v.xerr ? 0 : int'(v.xn)), {tag, " word count"}, 32'(moved), v.xerr ? 32'd0 : 32'(v.xn));
    if (v.rd) begin
      exp_rd = '0;
      if (!v.xerr) for (int j = 0; j < int'(v.xn); j++) exp_rd |= (src_word(base + j) & m) << (j * lane);
      chk(bus_rdata == exp_rd, {tag, " read data"}, bus_rdata, exp_rd);
    end else if (!v.xerr) begin
      for (int j = 0; j < int'(v.xn) && j < ncap; j++)
        chk(cap[j] == ((v.wd >> (j * lane)) & m), {tag, " tx word"}, cap[j], (v.wd >> (j * lane)) & m);
      chk(bus_rdata == 32'h0, "R5 rdata on write", bus_rdata, 32'h0);
    end
    bus_req = 1'b0;
    @(negedge clk);
    chk(!bus_ack, "R11 single-cycle ack", 32'(bus_ack), 32'd0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_ack && !bus_err, "R1 ack/err in reset", {30'h0, bus_ack, bus_err}, 32'h0);
    chk(!tx_valid && !rx_ready, "R1 handshakes in reset", {30'h0, tx_valid, rx_ready}, 32'h0);
    chk(bus_rdata == 32'h0, "R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_ack && !tx_valid && !rx_ready, "R1 idle after reset", {29'h0, bus_ack, tx_valid, rx_ready}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);

    // R10 back-pressure on the transmit side: four words, ready every other cycle
    bp = 1'b1;
    run_vec('{1'b1,1'b1,6'd5,2'b11,2'b11,8'h00,1'b0,2'd2,32'h1F2E_3D4C,4'd8,3'd4,1'b0,1'b0}, 7);
    bp = 1'b0;
    // R8 boundary: room for exactly four words is enough
    run_vec('{1'b1,1'b1,6'd7,2'b11,2'b11,8'h04,1'b0,2'd2,32'h8081_FF7F,4'd4,3'd4,1'b0,1'b0}, 0);
    // R9 boundary: exactly two words available is enough
    run_vec('{1'b1,1'b1,6'd15,2'b11,2'b11,8'h00,1'b1,2'd2,32'h0,4'd2,3'd2,1'b0,1'b0}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule